// File: doc/BRIEF.md
# Byte-Wide Logic and Arithmetic Unit with Flag Update

This block is the single-cycle byte datapath of a small microcontroller core. Each cycle it receives an operation code, a destination operand, a second register operand and an immediate constant. From these it forms a result of the data width and a set of status flags.

Every operation has its own set of flags that it writes. Alongside the result, the unit drives two flag vectors:
- a write-enable mask, so the flag register can hold bits the operation does not own;
- the merged next flag vector, in which unowned bits are copied from the current flags.

The unit is purely combinational. The surrounding core registers `res_o` and `flags_o` at its clock edge, which gives the one-clock completion of every operation.

Flag vector bit positions: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half-carry (H).

Operation codes on `op_i`:

| Code | Operation |
|---|---|
| 0 | AND with register |
| 1 | AND with immediate |
| 2 | OR with register |
| 3 | OR with immediate |
| 4 | XOR with register |
| 5 | XOR with immediate |
| 6 | one's complement |
| 7 | negate |
| 8 | set bits |
| 9 | clear bits |
| 10 | increment |
| 11 | decrement |
| 12 | test |
| 13 | clear |
| 14 | set all |
| 15 | reserved |

Top module: `byte_alu`

## Requirements
- R1: Codes 0, 2 and 4 give `rd_i` AND, OR and XOR `rr_i` respectively. Each sets `flag_we_o` to 0x1E (Z, N, V, S).
- R2: Codes 1, 3 and 5 use `imm_i` in place of `rr_i`. For these codes, `rr_i` has no effect on any output.
- R3: For every logic operation (codes 0-5, 8, 9, 12, 13), the flags are set as follows: Z is 1 exactly when the result is zero, N is the result's top bit, V is 0, and S is N XOR V.
- R4: Code 8 gives `rd_i` OR `imm_i`, and code 9 gives `rd_i` AND the inverse of `imm_i`. Both write mask 0x1E.
- R5: Code 6 gives all-ones minus `rd_i`. It writes mask 0x1F, with C=1 and V=0.
- R6: Code 7 gives zero minus `rd_i` and writes mask 0x3F. C is 1 unless the result is zero, V is 1 exactly when the result is 0x80, and H is 1 exactly when the low nibble of `rd_i` is non-zero.
- R7: Codes 10 and 11 give `rd_i` plus one and `rd_i` minus one, with wrap-around, and write mask 0x1E, so C and H are kept. V is 1 for increment exactly when the result is 0x80, and for decrement exactly when the result is 0x7F.
- R8: Code 12 returns `rd_i` unchanged, and code 13 returns zero with Z=1.
- R9: Code 14 returns all ones, writes mask 0, and leaves `flags_o` equal to `flags_i`.
- R10: Every bit of `flags_o` whose mask bit is 0 equals the same bit of `flags_i`. Whenever S is written, it equals N XOR V.
- R11: Reserved code 15 returns `rd_i` and writes mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| rd_i | input | DATA_W | Destination operand |
| rr_i | input | DATA_W | Second register operand |
| imm_i | input | DATA_W | Immediate constant |
| flags_i | input | 6 | Current flag register value |
| res_o | output | DATA_W | Operation result |
| flags_o | output | 6 | Next flag value, with unowned bits held |
| flag_we_o | output | 6 | Per-flag write-enable mask |

## Verification
The bench builds the block with the default DATA_W of 8. At that width, the overflow and half-carry boundaries fall on concrete byte values: 0x80, 0x7F and nibble 0. Exhaustive sweeps of increment, decrement and negation over all 256 operands therefore reach every wrap and every overflow point. Table vectors preload different flag patterns, so that kept bits are seen to survive. Further runs vary `rr_i` under immediate codes to show it has no effect.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_ANDK = 4'd1,
    OP_OR   = 4'd2,
    OP_ORK  = 4'd3,
    OP_XOR  = 4'd4,
    OP_XORK = 4'd5,
    OP_INV  = 4'd6,
    OP_NEG  = 4'd7,
    OP_SETB = 4'd8,
    OP_CLRB = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_TEST = 4'd12,
    OP_ZERO = 4'd13,
    OP_ONES = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [NFLAG-1:0] MASK_ZNVS  = 6'b011110;
  localparam logic [NFLAG-1:0] MASK_CZNVS = 6'b011111;
  localparam logic [NFLAG-1:0] MASK_ALL   = 6'b111111;

endpackage

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] k,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] opnd;

  // immediate forms replace the register operand
  always_comb begin
    opnd = b;
    if (op == OP_ANDK || op == OP_ORK || op == OP_XORK) opnd = k;
  end

  always_comb begin
    case (op)
      OP_AND, OP_ANDK: res = a & opnd;
      OP_OR,  OP_ORK:  res = a | opnd;
      OP_XOR, OP_XORK: res = a ^ opnd;
      OP_SETB:         res = a | k;
      OP_CLRB:         res = a & ~k;
      OP_TEST:         res = a;
      OP_ZERO:         res = '0;
      OP_ONES:         res = '1;
      default:         res = a;
    endcase
  end

endmodule

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              ov,
  output logic              hf
);

  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
  localparam logic [DATA_W-1:0] ALL_ONE  = '1;
  localparam logic [DATA_W-1:0] ZERO     = '0;
  localparam logic [DATA_W-1:0] MIN_NEG  = ONE << (DATA_W-1);
  localparam logic [DATA_W-1:0] MAX_POS  = ~MIN_NEG;
  localparam int               NIB      = 4;

  always_comb begin
    res = '0;
    cy  = 1'b0;
    ov  = 1'b0;
    hf  = 1'b0;
    case (op)
      OP_INV: begin
        res = ALL_ONE - a;
        cy  = 1'b1;
      end
      OP_NEG: begin
        res = ZERO - a;
        cy  = |res;
        ov  = (res == MIN_NEG);
        hf  = |a[NIB-1:0];   // borrow out of the low nibble
      end
      OP_INC: begin
        res = a + ONE;
        ov  = (res == MIN_NEG);
      end
      OP_DEC: begin
        res = a - ONE;
        ov  = (res == MAX_POS);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] res,
  input  logic              cy,
  input  logic              ov,
  input  logic              hf,
  input  logic [NFLAG-1:0]  flags_i,
  output logic [NFLAG-1:0]  flags_o,
  output logic [NFLAG-1:0]  we_o
);

  logic [NFLAG-1:0] nxt;
  logic [NFLAG-1:0] we;

  always_comb begin
    nxt     = '0;
    nxt[FC] = cy;
    nxt[FZ] = ~|res;
    nxt[FN] = res[DATA_W-1];
    nxt[FV] = ov;
    nxt[FS] = nxt[FN] ^ nxt[FV];
    nxt[FH] = hf;
  end

  always_comb begin
    case (op)
      OP_INV:           we = MASK_CZNVS;
      OP_NEG:           we = MASK_ALL;
      OP_ONES, OP_RSVD: we = '0;
      default:          we = MASK_ZNVS;
    endcase
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_merge
    assign flags_o[i] = we[i] ? nxt[i] : flags_i[i];
  end

  assign we_o = we;

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic [DATA_W-1:0] rr_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [NFLAG-1:0]  flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [NFLAG-1:0]  flag_we_o
);

  alu_op_e           op;
  logic [DATA_W-1:0] res_logic;
  logic [DATA_W-1:0] res_arith;
  logic              is_arith;
  logic              cy, ov, hf;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_INV) || (op == OP_NEG) ||
                    (op == OP_INC) || (op == OP_DEC);

  byte_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op (op),
    .a  (rd_i),
    .b  (rr_i),
    .k  (imm_i),
    .res(res_logic)
  );

  byte_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op (op),
    .a  (rd_i),
    .res(res_arith),
    .cy (cy),
    .ov (ov),
    .hf (hf)
  );

  always_comb begin
    res_o = is_arith ? res_arith : res_logic;
  end

  byte_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .op     (op),
    .res    (res_o),
    .cy     (cy),
    .ov     (ov),
    .hf     (hf),
    .flags_i(flags_i),
    .flags_o(flags_o),
    .we_o   (flag_we_o)
  );

  always_comb begin
    a_r10_hold_unowned: assert ((flags_o & ~flag_we_o) == (flags_i & ~flag_we_o));
    if (flag_we_o[FS])
      a_r10_sign_rule: assert (flags_o[FS] == (flags_o[FN] ^ flags_o[FV]));
    if (flag_we_o[FZ])
      a_r3_zero_flag: assert (flags_o[FZ] == (res_o == '0));
    if (op == OP_ONES)
      a_r9_ones_quiet: assert (flag_we_o == '0 && res_o == '1);
    if (op == OP_NEG)
      a_r6_neg_carry: assert (flags_o[FC] == (res_o != '0));
    if (op == OP_INC || op == OP_DEC)
      a_r7_keep_carry: assert (!flag_we_o[FC] && !flag_we_o[FH]);
  end

endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;

  logic       clk;
  logic [3:0] op;
  logic [7:0] rd, rr, imm, res;
  logic [5:0] fin, fout, we;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  byte_alu #(.DATA_W(8)) u0 (
    .op_i(op), .rd_i(rd), .rr_i(rr), .imm_i(imm), .flags_i(fin),
    .res_o(res), .flags_o(fout), .flag_we_o(we)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] op;
    logic [7:0] rd, rr, k;
    logic [5:0] fin;
    logic [7:0] res;
    logic [5:0] fout, we;
  } vec_t;

  // flags {H,S,V,N,Z,C}
  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  4'd0,  8'hF0, 8'h3C, 8'h00, 6'h21, 8'h30, 6'h21, 6'h1E}, // R1 AND
    '{4'd2,  4'd1,  8'h0F, 8'hFF, 8'hF0, 6'h0E, 8'h00, 6'h02, 6'h1E}, // R2 ANDI
    '{4'd1,  4'd2,  8'h80, 8'h01, 8'h00, 6'h00, 8'h81, 6'h14, 6'h1E}, // R1 OR
    '{4'd2,  4'd3,  8'h00, 8'h55, 8'h00, 6'h3F, 8'h00, 6'h23, 6'h1E}, // R2 ORI
    '{4'd1,  4'd4,  8'hAA, 8'h55, 8'h00, 6'h00, 8'hFF, 6'h14, 6'h1E}, // R1 XOR
    '{4'd3,  4'd5,  8'hAA, 8'h00, 8'hAA, 6'h01, 8'h00, 6'h03, 6'h1E}, // R3 XORI zero
    '{4'd5,  4'd6,  8'h00, 8'h00, 8'h00, 6'h20, 8'hFF, 6'h35, 6'h1F}, // R5
    '{4'd5,  4'd6,  8'hFF, 8'h00, 8'h00, 6'h00, 8'h00, 6'h03, 6'h1F}, // R5
    '{4'd6,  4'd7,  8'h01, 8'h00, 8'h00, 6'h00, 8'hFF, 6'h35, 6'h3F}, // R6
    '{4'd6,  4'd7,  8'h00, 8'h00, 8'h00, 6'h3F, 8'h00, 6'h02, 6'h3F}, // R6 zero
    '{4'd6,  4'd7,  8'h80, 8'h00, 8'h00, 6'h00, 8'h80, 6'h0D, 6'h3F}, // R6 0x80
    '{4'd6,  4'd7,  8'h10, 8'h00, 8'h00, 6'h00, 8'hF0, 6'h15, 6'h3F}, // R6 nibble 0
    '{4'd4,  4'd8,  8'h01, 8'h00, 8'h80, 6'h00, 8'h81, 6'h14, 6'h1E}, // R4 set bits
    '{4'd4,  4'd9,  8'hFF, 8'hFF, 8'h0F, 6'h00, 8'hF0, 6'h14, 6'h1E}, // R4 clear bits
    '{4'd7,  4'd10, 8'h7F, 8'h00, 8'h00, 6'h21, 8'h80, 6'h2D, 6'h1E}, // R7 inc ovf
    '{4'd7,  4'd10, 8'hFF, 8'h00, 8'h00, 6'h00, 8'h00, 6'h02, 6'h1E}, // R7 inc wrap
    '{4'd7,  4'd11, 8'h80, 8'h00, 8'h00, 6'h00, 8'h7F, 6'h18, 6'h1E}, // R7 dec ovf
    '{4'd7,  4'd11, 8'h00, 8'h00, 8'h00, 6'h01, 8'hFF, 6'h15, 6'h1E}, // R7 dec wrap
    '{4'd8,  4'd12, 8'h80, 8'h00, 8'h00, 6'h08, 8'h80, 6'h14, 6'h1E}, // R8 test
    '{4'd8,  4'd12, 8'h00, 8'h00, 8'h00, 6'h00, 8'h00, 6'h02, 6'h1E}, // R8 test zero
    '{4'd8,  4'd13, 8'h5A, 8'h00, 8'h00, 6'h15, 8'h00, 6'h03, 6'h1E}, // R8 clear
    '{4'd9,  4'd14, 8'h12, 8'h00, 8'h00, 6'h2A, 8'hFF, 6'h2A, 6'h00}, // R9 set all
    '{4'd11, 4'd15, 8'h5C, 8'h00, 8'h00, 6'h15, 8'h5C, 6'h15, 6'h00}  // R11 reserved
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] k, input logic [5:0] f);
    @(negedge clk);
    op = o; rd = a; rr = b; imm = k; fin = f;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [5:0] logic_flags(input logic [7:0] r, input logic [5:0] f);
    logic [5:0] x;
    x    = f;
    x[1] = (r == 8'h00);
    x[2] = r[7];
    x[3] = 1'b0;
    x[4] = r[7];
    return x;
  endfunction

  initial begin
    op = 4'd0; rd = 8'h00; rr = 8'h00; imm = 8'h00; fin = 6'h00;
    @(posedge clk); #2;
    // idle pattern: AND of zeros
    check("R3 idle res", res, 8'h00);
    check("R3 idle flags", {2'b0, fout}, 8'h02);

    for (int i = 0; i < NV; i++) begin
      string tag;
      apply(TBL[i].op, TBL[i].rd, TBL[i].rr, TBL[i].k, TBL[i].fin);
      tag = $sformatf("R%0d row %0d", TBL[i].req, i);
      check({tag, " res"}, res, TBL[i].res);
      check({tag, " flags"}, {2'b0, fout}, {2'b0, TBL[i].fout});
      check({tag, " mask"}, {2'b0, we}, {2'b0, TBL[i].we});
    end

    // R2: rr_i ignored under immediate codes
    for (int j = 0; j < 3; j++) begin
      logic [7:0] b;
      b = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : 8'hA5;
      apply(4'd1, 8'hFF, b, 8'h3C, 6'h00);
      check("R2 andi rr", res, 8'h3C);
      apply(4'd3, 8'h01, b, 8'h40, 6'h00);
      check("R2 ori rr", res, 8'h41);
      apply(4'd5, 8'hF0, b, 8'hFF, 6'h00);
      check("R2 xori rr", res, 8'h0F);
      check("R2 xori flags", {2'b0, fout}, {2'b0, logic_flags(8'h0F, 6'h00)});
    end

    // R7 increment / decrement sweeps with C and H preloaded
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      logic [5:0] e;
      r = 8'(v + 1);
      e = logic_flags(r, 6'h21);
      e[3] = (r == 8'h80);
      e[4] = r[7] ^ e[3];
      apply(4'd10, 8'(v), 8'h00, 8'h00, 6'h21);
      check("R7 inc res", res, r);
      check("R7 inc flags", {2'b0, fout}, {2'b0, e});
      r = 8'(v - 1);
      e = logic_flags(r, 6'h21);
      e[3] = (r == 8'h7F);
      e[4] = r[7] ^ e[3];
      apply(4'd11, 8'(v), 8'h00, 8'h00, 6'h21);
      check("R7 dec res", res, r);
      check("R7 dec flags", {2'b0, fout}, {2'b0, e});
    end

    // R6 negate sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      logic [5:0] e;
      r = 8'(0 - v);
      e[0] = (r != 8'h00);
      e[1] = (r == 8'h00);
      e[2] = r[7];
      e[3] = (r == 8'h80);
      e[4] = r[7] ^ e[3];
      e[5] = (v[3:0] != 4'h0);
      apply(4'd7, 8'(v), 8'h00, 8'h00, 6'h00);
      check("R6 neg res", res, r);
      check("R6 neg flags", {2'b0, fout}, {2'b0, e});
    end

    // R9 / R10: set-all holds every flag pattern
    for (int f = 0; f < 64; f += 9) begin
      apply(4'd14, 8'h00, 8'h00, 8'h00, 6'(f));
      check("R10 hold flags", {2'b0, fout}, 8'(f));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule